// File: doc/BRIEF.md
# Vectored Interrupt Controller with Per-Source Routing

This block gathers 64 raw interrupt lines and turns them into eight request outputs: a normal request, a fast request and six auxiliary requests. Each line owns one configuration byte that turns it on, chooses how it triggers (a high level, a rising edge, a falling edge or either edge) and names the output it drives. Edges are caught in sticky status bits that software clears by writing ones.

Software reaches the configuration bytes, the status words and two priority registers through a small register port with a write strobe, a read strobe and a combinational read path. Each priority register returns the number of the source that currently wins for its output, together with a flag that tells whether any source is pending. Priority is either fixed, where the lowest number wins, or rotating, where a serviced source drops to the back of the queue.

Top module: `vec_intc`

## Requirements
- R1: After reset every configuration byte, both status words and both rotate bits read as zero, and all eight request outputs are low.
- R2: The configuration byte of source n is written from bus_wdata[7:0] and read back on bus_rdata[7:0] at byte address 0x40+n; the upper read bits are zero.
- R3: A source whose configuration bit 3 is clear drives no request output and no priority result, while its edge status bit still latches.
- R4: With configuration bits 6:5 equal to 00 a source is pending while its input is high; a change of the input shows at the request outputs one clock after the edge that samples it.
- R5: Bit 5 alone selects rising-edge, bit 6 alone falling-edge and both bits either-edge triggering; a matching edge, judged against the input sampled one clock earlier, sets the status bit, and the source is pending while that bit is set.
- R6: Status for sources 0 to 31 reads at 0x80 and for sources 32 to 63 at 0x84, at bit position n mod 32; writing a 1 clears that bit, writing a 0 leaves it, and an edge arriving in the same cycle as the clear keeps the bit set.
- R7: Configuration bits 2:0 choose the output: 0 the normal request, 1 the fast request, 2 to 7 auxiliary requests 0 to 5; each output is high whenever an enabled pending source is routed to it.
- R8: The priority register at 0x20 (normal output) and at 0x24 (fast output) reads bit 31 as the pending flag, bit 6 as the rotate bit (writable) and bits 5:0 as the winning source, which reads 0 when nothing is pending.
- R9: With the rotate bit clear, the lowest-numbered pending source routed to that output wins, and reading the register changes nothing.
- R10: With the rotate bit set, a read of the priority register while its pending flag is set marks the winner as serviced, and the next search starts at winner+1, wrapping from 63 to 0; the start point is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 64 | Raw interrupt lines, one per source |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (advances the rotating start point) |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| irq_req | output | 1 | Normal interrupt request |
| fiq_req | output | 1 | Fast interrupt request |
| aux_req | output | 6 | Auxiliary interrupt requests 0 to 5 |

## Verification
A status bit that fails to clear keeps its routed request high and its number in the priority register on the very next cycle after the clearing write, so the bench reads both back right after each clean-up. A wrong enable or route decode appears one clock after the input changes as a request on the wrong output, which the vector table checks on every line. A start pointer that advances wrongly shows on the next priority read as the wrong source number, so the rotating sequence is read out step by step through a wrap.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int CTL_W     = 8;
  localparam int DEST_W    = 3;
  localparam int NDEST     = 8;
  localparam int NAUX      = NDEST - 2;
  localparam int BUS_W     = 32;
  localparam int ADDR_W    = 8;
  localparam int EN_BIT    = 3;
  localparam int RISE_BIT  = 5;
  localparam int FALL_BIT  = 6;
  localparam int ROT_BIT   = 6;
  localparam int VALID_BIT = 31;

  localparam logic [ADDR_W-1:0] OFS_IRQ_PRI = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_FIQ_PRI = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_CTL     = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_STAT    = 8'h80;

  localparam logic [DEST_W-1:0] DST_IRQ = 3'd0;
  localparam logic [DEST_W-1:0] DST_FIQ = 3'd1;

  function automatic logic ctl_enabled(input logic [CTL_W-1:0] c);
    return c[EN_BIT];
  endfunction

  function automatic logic ctl_is_edge(input logic [CTL_W-1:0] c);
    return c[RISE_BIT] | c[FALL_BIT];
  endfunction

  function automatic logic [DEST_W-1:0] ctl_dest(input logic [CTL_W-1:0] c);
    return c[DEST_W-1:0];
  endfunction

  function automatic logic edge_match(input logic [CTL_W-1:0] c,
                                      input logic now, input logic prev);
    return (c[RISE_BIT] & now & ~prev) | (c[FALL_BIT] & ~now & prev);
  endfunction
endpackage

// File: rtl/vic_src_slice.sv
module vic_src_slice
  import vic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_raw,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic              stat_clr,
  output logic [CTL_W-1:0]  ctl_q,
  output logic              stat_q,
  output logic              pend_en,
  output logic [DEST_W-1:0] dest
);
  logic raw_q;
  logic edge_hit;

  assign edge_hit = edge_match(ctl_q, src_raw, raw_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      raw_q  <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      raw_q <= src_raw;
      if (ctl_we) ctl_q <= ctl_wdata;
      if (edge_hit)      stat_q <= 1'b1;
      else if (stat_clr) stat_q <= 1'b0;
    end
  end

  assign pend_en = ctl_enabled(ctl_q) & (ctl_is_edge(ctl_q) ? stat_q : raw_q);
  assign dest    = ctl_dest(ctl_q);

  // R5: a matching edge is latched
  a_r5_edge_latch: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> stat_q);

  // R6: write-one clear without a competing edge empties the bit
  a_r6_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !edge_hit) |=> !stat_q);

  // R3: a disabled source never contributes
  a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[EN_BIT] |-> !pend_en);
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
  parameter int N  = 64,
  parameter int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_vec,
  input  logic          rotate,
  input  logic          ack_rd,
  output logic [SW-1:0] win,
  output logic          valid
);
  logic [SW-1:0] ptr;
  logic [SW-1:0] start;
  logic          ack;

  function automatic logic [SW:0] pick(input logic [N-1:0] v, input logic [SW-1:0] st);
    logic [SW:0]   r;
    logic [SW-1:0] k;
    r = '0;
    for (int i = 0; i < N; i++) begin
      k = st + SW'(i);
      if (!r[SW] && v[k]) r = {1'b1, k};
    end
    return r;
  endfunction

  function automatic logic none_below(input logic [N-1:0] v, input logic [SW-1:0] w);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < N; i++)
      if (i < int'(w) && v[i]) hit = 1'b1;
    return !hit;
  endfunction

  assign start        = rotate ? ptr : '0;
  assign {valid, win} = pick(req_vec, start);
  assign ack          = ack_rd & rotate & valid;

  always_ff @(posedge clk) begin
    if (!rst_n)   ptr <= '0;
    else if (ack) ptr <= win + SW'(1);
  end

  // R8: the reported winner is really pending
  a_r8_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> req_vec[win]);

  // R9: fixed priority picks the lowest number
  a_r9_fixed_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !rotate) |-> none_below(req_vec, win));

  // R10: a serviced winner moves the start just past itself
  a_r10_rot_step: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (ptr == $past(win) + SW'(1)));
endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import vic_pkg::*;
#(
  parameter int NSRC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_in,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq_req,
  output logic              fiq_req,
  output logic [NAUX-1:0]   aux_req
);
  localparam int SW    = $clog2(NSRC);
  localparam int NWORD = NSRC / BUS_W;

  logic [CTL_W-1:0]  ctl_arr  [NSRC];
  logic [DEST_W-1:0] dest_arr [NSRC];
  logic [NSRC-1:0]   stat_all, pend_en, ctl_we, stat_clr;
  logic [NSRC-1:0]   route_vec [NDEST];
  logic [NDEST-1:0]  req;

  logic          ctl_hit, stat_hit;
  logic [SW-1:0] ctl_idx;
  int            stat_word;
  logic          rot_irq, rot_fiq;
  logic [SW-1:0] irq_win, fiq_win;
  logic          irq_valid, fiq_valid;

  // address decode
  assign ctl_hit   = int'(bus_addr) >= int'(OFS_CTL) &&
                     int'(bus_addr) <  int'(OFS_CTL) + NSRC;
  assign ctl_idx   = SW'(int'(bus_addr) - int'(OFS_CTL));
  assign stat_hit  = int'(bus_addr) >= int'(OFS_STAT) &&
                     int'(bus_addr) <  int'(OFS_STAT) + 4 * NWORD &&
                     bus_addr[1:0] == 2'b00;
  assign stat_word = (int'(bus_addr) - int'(OFS_STAT)) / 4;

  for (genvar n = 0; n < NSRC; n++) begin : g_src
    assign ctl_we[n]   = bus_wr && ctl_hit && ctl_idx == SW'(n);
    assign stat_clr[n] = bus_wr && stat_hit && stat_word == n / BUS_W &&
                         bus_wdata[n % BUS_W];
    vic_src_slice u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_raw   (src_in[n]),
      .ctl_we    (ctl_we[n]),
      .ctl_wdata (bus_wdata[CTL_W-1:0]),
      .stat_clr  (stat_clr[n]),
      .ctl_q     (ctl_arr[n]),
      .stat_q    (stat_all[n]),
      .pend_en   (pend_en[n]),
      .dest      (dest_arr[n])
    );
  end

  // routing to the eight outputs
  for (genvar d = 0; d < NDEST; d++) begin : g_dest
    always_comb begin
      for (int n = 0; n < NSRC; n++)
        route_vec[d][n] = pend_en[n] && dest_arr[n] == DEST_W'(d);
    end
    assign req[d] = |route_vec[d];
  end

  assign irq_req = req[DST_IRQ];
  assign fiq_req = req[DST_FIQ];
  assign aux_req = req[NDEST-1:2];

  // rotate bits
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rot_irq <= 1'b0;
      rot_fiq <= 1'b0;
    end else if (bus_wr) begin
      if (bus_addr == OFS_IRQ_PRI) rot_irq <= bus_wdata[ROT_BIT];
      if (bus_addr == OFS_FIQ_PRI) rot_fiq <= bus_wdata[ROT_BIT];
    end
  end

  vic_arbiter #(.N(NSRC), .SW(SW)) u_arb_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_vec (route_vec[DST_IRQ]),
    .rotate  (rot_irq),
    .ack_rd  (bus_rd && bus_addr == OFS_IRQ_PRI),
    .win     (irq_win),
    .valid   (irq_valid)
  );

  vic_arbiter #(.N(NSRC), .SW(SW)) u_arb_fiq (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_vec (route_vec[DST_FIQ]),
    .rotate  (rot_fiq),
    .ack_rd  (bus_rd && bus_addr == OFS_FIQ_PRI),
    .win     (fiq_win),
    .valid   (fiq_valid)
  );

  // read path
  always_comb begin
    bus_rdata = '0;
    if (ctl_hit) begin
      bus_rdata[CTL_W-1:0] = ctl_arr[ctl_idx];
    end else if (stat_hit) begin
      bus_rdata = stat_all[stat_word*BUS_W +: BUS_W];
    end else if (bus_addr == OFS_IRQ_PRI) begin
      bus_rdata[VALID_BIT] = irq_valid;
      bus_rdata[ROT_BIT]   = rot_irq;
      bus_rdata[SW-1:0]    = irq_win;
    end else if (bus_addr == OFS_FIQ_PRI) begin
      bus_rdata[VALID_BIT] = fiq_valid;
      bus_rdata[ROT_BIT]   = rot_fiq;
      bus_rdata[SW-1:0]    = fiq_win;
    end
  end

  // R7: the routed OR and the arbiter agree on whether anything waits
  a_r7_irq_agree: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req == irq_valid);
  a_r7_fiq_agree: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_req == fiq_valid);
endmodule

// File: tb/tb_vec_intc.sv
`timescale 1ns/1ps
module tb_vec_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_in = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_req, fiq_req;
  logic [5:0]  aux_req;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vec_intc dut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .fiq_req(fiq_req), .aux_req(aux_req)
  );

  // row: {src[5:0], ctl[7:0], pulse, exp_irq, exp_fiq, exp_aux[5:0]}
  localparam logic [22:0] TBL [12] = '{
    {6'd5,  8'h08, 1'b0, 1'b1, 1'b0, 6'b000000}, // R4 R7 level to normal
    {6'd5,  8'h00, 1'b0, 1'b0, 1'b0, 6'b000000}, // R3 disabled level
    {6'd40, 8'h09, 1'b0, 1'b0, 1'b1, 6'b000000}, // R7 fast
    {6'd63, 8'h0A, 1'b0, 1'b0, 1'b0, 6'b000001}, // R7 aux0
    {6'd17, 8'h0F, 1'b0, 1'b0, 1'b0, 6'b100000}, // R7 aux5
    {6'd2,  8'h28, 1'b1, 1'b1, 1'b0, 6'b000000}, // R5 rising latched
    {6'd2,  8'h48, 1'b0, 1'b0, 1'b0, 6'b000000}, // R5 falling, no fall yet
    {6'd33, 8'h49, 1'b1, 1'b0, 1'b1, 6'b000000}, // R5 falling latched
    {6'd10, 8'h08, 1'b1, 1'b0, 1'b0, 6'b000000}, // R4 level released
    {6'd50, 8'h2C, 1'b0, 1'b0, 1'b0, 6'b000100}, // R5 rising aux2
    {6'd0,  8'h68, 1'b1, 1'b1, 1'b0, 6'b000000}, // R5 either edge
    {6'd20, 8'h20, 1'b1, 1'b0, 1'b0, 6'b000000}  // R3 disabled edge
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic logic [31:0] outs();
    return {24'b0, irq_req, fiq_req, aux_req};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h45, v); chk("R1 ctl byte", v, 32'h0);
    rd(8'h80, v); chk("R1 status lo", v, 32'h0);
    rd(8'h84, v); chk("R1 status hi", v, 32'h0);
    rd(8'h20, v); chk("R1 irq prio", v, 32'h0);
    chk("R1 outputs", outs(), 32'h0);

    // R2 configuration read-back
    wr(8'h47, 32'hFFFF_FFA5);
    rd(8'h47, v); chk("R2 ctl 7", v, 32'h0000_00A5);
    wr(8'h7F, 32'h17);
    rd(8'h7F, v); chk("R2 ctl 63", v, 32'h17);
    wr(8'h47, 0); wr(8'h7F, 0);

    // table of single-source cases (R3 R4 R5 R7)
    for (int i = 0; i < 12; i++) begin
      logic [5:0] s;
      logic [7:0] c;
      s = TBL[i][22:17];
      c = TBL[i][16:9];
      wr(8'h40 + {2'b00, s}, {24'b0, c});
      @(negedge clk); src_in[s] = 1'b1;
      if (TBL[i][8]) begin @(negedge clk); src_in[s] = 1'b0; end
      repeat (2) @(negedge clk);
      chk($sformatf("R7 table row %0d", i), outs(), {24'b0, TBL[i][7:0]});
      wr(8'h40 + {2'b00, s}, 0);
      src_in[s] = 1'b0;
      @(negedge clk);
      wr(8'h80, 32'hFFFF_FFFF);
      wr(8'h84, 32'hFFFF_FFFF);
    end
    chk("R6 table cleanup", outs(), 32'h0);

    // R4 one-cycle latency
    wr(8'h4C, 32'h08);
    @(negedge clk); src_in[12] = 1'b1;
    #1 chk("R4 not yet high", {31'b0, irq_req}, 32'h0);
    @(negedge clk); chk("R4 high after one clock", {31'b0, irq_req}, 32'h1);
    src_in[12] = 1'b0;
    #1 chk("R4 still high", {31'b0, irq_req}, 32'h1);
    @(negedge clk); chk("R4 low after one clock", {31'b0, irq_req}, 32'h0);
    wr(8'h4C, 0);

    // R6 status words, R3 latch while disabled
    wr(8'h43, 32'h20); wr(8'h63, 32'h20);
    @(negedge clk); src_in[3] = 1'b1; src_in[35] = 1'b1;
    repeat (2) @(negedge clk);
    src_in[3] = 1'b0; src_in[35] = 1'b0;
    rd(8'h80, v); chk("R6 word0 bit3", v, 32'h8);
    rd(8'h84, v); chk("R6 word1 bit3", v, 32'h8);
    chk("R3 disabled no request", outs(), 32'h0);
    wr(8'h80, 32'h0);
    rd(8'h80, v); chk("R6 zero write keeps", v, 32'h8);
    wr(8'h80, 32'h8);
    rd(8'h80, v); chk("R6 one clears", v, 32'h0);
    rd(8'h84, v); chk("R6 other word kept", v, 32'h8);
    // R6 edge and clear in the same cycle: edge wins
    wr(8'h63, 32'h28);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h84; bus_wdata = 32'h8; src_in[35] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(8'h84, v); chk("R6 edge beats clear", v, 32'h8);
    src_in[35] = 1'b0;
    wr(8'h43, 0); wr(8'h63, 0); wr(8'h84, 32'hFFFF_FFFF);

    // R9 fixed priority, R10 rotation
    wr(8'h44, 32'h08); wr(8'h49, 32'h08); wr(8'h5E, 32'h08);
    @(negedge clk); src_in[4] = 1'b1; src_in[9] = 1'b1; src_in[30] = 1'b1;
    repeat (2) @(negedge clk);
    rd(8'h20, v); chk("R9 fixed lowest", v, 32'h8000_0004);
    rd(8'h20, v); chk("R9 fixed unchanged by read", v, 32'h8000_0004);
    rd(8'h24, v); chk("R8 fast empty", v, 32'h0);
    wr(8'h20, 32'h40);
    rd(8'h20, v); chk("R10 rot first", v, 32'h8000_0044);
    rd(8'h20, v); chk("R10 rot second", v, 32'h8000_0049);
    rd(8'h20, v); chk("R10 rot third", v, 32'h8000_005E);
    rd(8'h20, v); chk("R10 rot wrap", v, 32'h8000_0044);
    wr(8'h20, 32'h0);
    rd(8'h20, v); chk("R9 back to fixed", v, 32'h8000_0004);
    src_in[4] = 1'b0; src_in[9] = 1'b0; src_in[30] = 1'b0;
    repeat (2) @(negedge clk);
    rd(8'h20, v); chk("R8 nothing pending", v, 32'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule